// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital control logic that sits in front of a 5-bit step attenuator. It produces the active attenuation code that drives the switching network. The code counts in 0.5 dB steps, from 0 (minimum loss) to 31 (maximum attenuation, 15.5 dB). A mode-select input chooses where new values come from.

In parallel operation, five pins carry the code directly. A shared latch-enable line makes the internal latch transparent while it is high. If latch enable is tied high, the pins act at once. If it is pulsed, the value on the pins at the pulse is captured. In serial operation, a three-wire port (data, clock, latch enable) fills an 8-bit shift register, least significant bit first. A high-then-low pulse on latch enable then moves the word into the active latch.

After reset the block holds maximum attenuation for a power-up window of `PWRUP_CYCLES` clock cycles. It then either applies the parallel pins (direct mode) or keeps maximum until something is latched. Every input is registered once on the system clock. Serial clock edges are found by comparing successive samples.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is asserted and for the first `PWRUP_CYCLES` clock edges after reset is released, `atten_code` is 31, whatever the other inputs do.
- R2: If `mode_ser`=0 and `latch_en`=1 across reset release, `atten_code` takes the value of `par_code` exactly `PWRUP_CYCLES`+1 rising clock edges after the release, and is still 31 one edge earlier.
- R3: If `latch_en` is low when the power-up window ends, `atten_code` stays 31 until a latch-enable pulse arrives.
- R4: `mode_ser`=0 selects `par_code` as the latch source. `mode_ser`=1 selects the low five bits of the serial shift register.
- R5: In parallel mode with `latch_en` high, a change on `par_code` shows on `atten_code` two rising clock edges later, and not one edge later.
- R6: While `latch_en` is low, `atten_code` holds and changes on `par_code` have no effect. A high-then-low pulse loads the value present during the pulse.
- R7: In serial mode with `latch_en` low, each rising edge of `ser_clk` shifts `ser_data` into bit 7 while the register moves toward bit 0. After 8 edges, the first bit sent sits in bit 0. `atten_code` does not change while shifting.
- R8: A latch-enable pulse in serial mode loads word bits [4:0] into `atten_code`. Bits 6 and 5 have no effect.
- R9: Bit 7 of the latched serial word is a lock. While a word with bit 7 set is latched, parallel mode leaves `atten_code` unchanged. Latching a serial word with bit 7 clear releases the lock. Reset clears it.
- R10: If more than 8 bits are shifted before a pulse, only the last 8 bits are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| mode_ser | input | 1 | 0: parallel control, 1: serial control |
| par_code | input | 5 | Parallel attenuation code |
| latch_en | input | 1 | Shared latch enable, transparent while high |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial data, LSB first |
| atten_code | output | 5 | Active attenuation code (31 = maximum) |

## Verification
The assertions assume that every input stays stable for at least two system clock cycles. This lets each serial clock level and each latch-enable level be sampled at least once, and lets a serial data bit be registered before its clock edge. They also assume that `par_code` is held at zero in serial mode, and that the serial word has bit 7 clear before the bench switches into parallel mode and expects the pins to take effect. The bench drives every input only on the falling clock edge. It holds each level for two or more cycles, grounds the parallel pins whenever serial mode is selected, and applies a locked word only in the one sequence that checks that parallel mode is ignored.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int SAC_CODE_W = 5;
  localparam int SAC_WORD_W = 8;
  localparam int SAC_LOCK_IDX = SAC_WORD_W - 1;

  typedef logic [SAC_CODE_W-1:0] code_t;
  typedef logic [SAC_WORD_W-1:0] word_t;

  localparam code_t CODE_MAX = '1;

  // attenuation code carried by a serial word: its low bits
  function automatic code_t word_code(word_t w);
    return w[SAC_CODE_W-1:0];
  endfunction

  // lock flag carried by a serial word: its top bit
  function automatic logic word_lock(word_t w);
    return w[SAC_LOCK_IDX];
  endfunction

  // one LSB-first shift: new bit enters at the top
  function automatic word_t shift_lsb_first(word_t w, logic b);
    return {b, w[SAC_WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/sac_in_stage.sv
module sac_in_stage
  import sac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_ser,
  input  code_t par_code,
  input  logic  latch_en,
  input  logic  ser_clk,
  input  logic  ser_data,
  output logic  mode_q,
  output code_t par_q,
  output logic  le_q,
  output logic  sdata_q,
  output logic  sclk_rise
);
  logic sclk_q, sclk_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      par_q   <= '0;
      le_q    <= 1'b0;
      sdata_q <= 1'b0;
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
    end else begin
      mode_q  <= mode_ser;
      par_q   <= par_code;
      le_q    <= latch_en;
      sdata_q <= ser_data;
      sclk_q  <= ser_clk;
      sclk_qq <= sclk_q;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_qq;

  // R7: a detected serial clock edge lasts exactly one cycle
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/sac_shift_reg.sv
module sac_shift_reg
  import sac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  bit_in,
  output word_t word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (shift_en) word <= shift_lsb_first(word, bit_in);
  end

  // R7: no movement without a qualified serial clock edge
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));
  // R7: the newest bit lands in the top position
  a_r7_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word[SAC_WORD_W-1] == $past(bit_in));
endmodule

// File: rtl/sac_pwrup_timer.sv
module sac_pwrup_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  // R1: once the window has ended it never reopens without reset
  a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import sac_pkg::*;
#(
  parameter int PWRUP_CYCLES = 20000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_ser,
  input  logic [SAC_CODE_W-1:0] par_code,
  input  logic                  latch_en,
  input  logic                  ser_clk,
  input  logic                  ser_data,
  output logic [SAC_CODE_W-1:0] atten_code
);
  logic  mode_q, le_q, sdata_q, sclk_rise;
  code_t par_q;
  word_t sr_word;
  logic  pwr_done;
  logic  shift_en;
  logic  lock_q;
  code_t act_q;

  sac_in_stage u_in (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .par_code(par_code),
    .latch_en(latch_en), .ser_clk(ser_clk), .ser_data(ser_data),
    .mode_q(mode_q), .par_q(par_q), .le_q(le_q), .sdata_q(sdata_q),
    .sclk_rise(sclk_rise)
  );

  assign shift_en = sclk_rise & mode_q & ~le_q;

  sac_shift_reg u_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sdata_q),
    .word(sr_word)
  );

  sac_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .done(pwr_done)
  );

  // active latch: transparent while latch enable is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= CODE_MAX;
      lock_q <= 1'b0;
    end else if (!pwr_done) begin
      act_q  <= CODE_MAX;
    end else if (le_q) begin
      if (mode_q) begin
        act_q  <= word_code(sr_word);
        lock_q <= word_lock(sr_word);
      end else if (!lock_q) begin
        act_q  <= par_q;
      end
    end
  end

  assign atten_code = act_q;

  // R1: maximum attenuation held through the power-up window
  a_r1_max_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |=> act_q == CODE_MAX);
  // R6: latch opaque while enable low
  a_r6_hold_le_low: assert property (@(posedge clk) disable iff (!rst_n)
    !le_q |=> $stable(act_q));
  // R7: shifting never disturbs the active code
  a_r7_stable_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(act_q));
  // R9: a locked latch ignores parallel mode
  a_r9_lock_blocks_par: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_done && lock_q && !mode_q) |=> $stable(act_q));
  // R9: lock only moves in serial mode with the latch open
  a_r9_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_q && le_q) |=> $stable(lock_q));
endmodule

// File: tb/step_atten_ctrl_tb_top.sv
`timescale 1ns/1ps
module step_atten_ctrl_tb_top;
  localparam int N = 200;
  localparam int WATCHDOG_NS = 2_000_000;

  typedef struct {
    logic [4:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ser = 1'b0;
  logic [4:0] par_code = 5'd9;
  logic       latch_en = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic [4:0] atten_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t sb_q[$];

  always #10 clk = ~clk;

  step_atten_ctrl #(.PWRUP_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .par_code(par_code),
    .latch_en(latch_en), .ser_clk(ser_clk), .ser_data(ser_data),
    .atten_code(atten_code)
  );

  // monitor: pops expected items 1 ns after they are pushed
  initial begin
    forever begin
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (atten_code !== it.exp) begin
          errors++;
          $display("FAIL %s: atten_code=%0d expected=%0d", it.tag, atten_code, it.exp);
        end
      end
    end
  end

  task automatic expect_code(input logic [4:0] v, input string tag);
    item_t it;
    it.exp = v;
    it.tag = tag;
    sb_q.push_back(it);
    #2;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic le_pulse();
    latch_en = 1'b1; tick(3);
    latch_en = 1'b0; tick(3);
  endtask

  task automatic shift_bits(input logic [15:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      ser_data = v[i]; tick(2);
      ser_clk = 1'b1; tick(2);
      ser_clk = 1'b0; tick(1);
    end
  endtask

  task automatic load_serial(input logic [7:0] w);
    shift_bits({8'h00, w}, 0, 7);
    le_pulse();
  endtask

  initial begin
    // R1: reset state
    tick(3);
    expect_code(5'd31, "R1 during reset");
    rst_n = 1'b1;
    // R2: direct-mode preset timing
    repeat (N) @(posedge clk);
    @(negedge clk);
    expect_code(5'd31, "R1 last window edge");
    @(negedge clk);
    expect_code(5'd9, "R2 preset after window");

    // R5: transparent parallel, two-edge latency
    par_code = 5'd17;
    tick(1); expect_code(5'd9, "R5 one edge");
    tick(1); expect_code(5'd17, "R5 two edges");

    // R6: latched parallel
    latch_en = 1'b0; tick(2);
    par_code = 5'd3; tick(4);
    expect_code(5'd17, "R6 pins ignored while low");
    le_pulse();
    expect_code(5'd3, "R6 pulse loads");
    par_code = 5'd22; tick(4);
    expect_code(5'd3, "R6 hold after pulse");

    // R4 / R7 / R8: serial
    par_code = 5'd0; mode_ser = 1'b1; tick(2);
    shift_bits(16'h000B, 0, 3);
    expect_code(5'd3, "R7 unchanged mid-shift");
    shift_bits(16'h000B, 4, 7);
    expect_code(5'd3, "R7 unchanged after shift");
    le_pulse();
    expect_code(5'd11, "R4 serial source");
    load_serial(8'h01);
    expect_code(5'd1, "R7 lsb first 0x01");
    load_serial(8'h10);
    expect_code(5'd16, "R7 lsb first 0x10");
    load_serial(8'h6D);
    expect_code(5'd13, "R8 bits 6:5 ignored");
    // R10: only last 8 bits kept
    shift_bits(16'h009F, 0, 11);
    le_pulse();
    expect_code(5'd9, "R10 last eight bits");

    // R9: lock
    load_serial(8'h85);
    expect_code(5'd5, "R9 locked word loads");
    mode_ser = 1'b0; par_code = 5'd20; latch_en = 1'b1; tick(5);
    expect_code(5'd5, "R9 parallel ignored when locked");
    latch_en = 1'b0; par_code = 5'd0; tick(2);
    mode_ser = 1'b1; tick(2);
    load_serial(8'h07);
    expect_code(5'd7, "R9 unlock word");
    mode_ser = 1'b0; par_code = 5'd20; latch_en = 1'b1; tick(5);
    expect_code(5'd20, "R4 parallel after unlock");

    // R1 / R3: second power-up in serial mode
    latch_en = 1'b0; par_code = 5'd0; mode_ser = 1'b1; tick(2);
    rst_n = 1'b0; tick(3);
    expect_code(5'd31, "R1 reset again");
    rst_n = 1'b1; tick(2);
    load_serial(8'h0C);
    expect_code(5'd31, "R1 pulse inside window");
    tick(N);
    expect_code(5'd31, "R3 stays max after window");
    le_pulse();
    expect_code(5'd12, "R3 first latch after window");

    tick(5);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(WATCHDOG_NS);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule